// File: doc/BRIEF.md
# Bi-quinary decimal decade

One decimal digit of a counting chain. Each counted event toggles a divide-by-2 stage. Each time that stage wraps from 1 to 0, a five-position one-hot ring moves on by one position. A small encoder turns the joint state into a standard BCD digit. The digit value is twice the ring position plus the toggle bit, so the decade steps through 0 to 9 in order.

The decade counts one event per clock cycle in which the count enable is high. When the digit passes from 9 to 0, the decade drives a carry output in that same cycle. Wiring that carry to the enable of the next decade gives a synchronous multi-digit counter. The same cell serves a measured-input chain and a timebase divider chain.

A synchronous clear and an asynchronous active-low reset both return the digit to 0. If the ring holds a pattern that is not one-hot, the encoder shows 0 and the next advance reloads position 0.

Top module: `bq_decade`

## Requirements
- R1: While rst_ni is low, and after its release until the first count, bcd_o reads 0 and carry_o is 0.
- R2: At a rising clock edge with en_i=1 and clr_i=0, bcd_o moves from value v to (v+1) mod 10.
- R3: At a rising clock edge with en_i=0 and clr_i=0, bcd_o keeps its value.
- R4: carry_o is 1 exactly when en_i=1, clr_i=0 and bcd_o=9, in the same cycle, with no register in between.
- R5: clr_i=1 sets bcd_o to 0 at the next edge, whatever the state of en_i, and forces carry_o to 0.
- R6: bcd_o never shows a value above 9. After a clear, ten enabled counts bring it back to 0 and raise carry_o on exactly one of them.
- R7: Seven decades chained carry_o to en_i show the decimal value of the total number of enabled counts since the last clear, with the first decade as the least significant digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable, one count per cycle |
| clr_i | input | 1 | Synchronous clear, overrides en_i |
| bcd_o | output | 4 | Current digit, BCD |
| carry_o | output | 1 | Wrap from 9 to 0 on this count |

## Verification
A wrong toggle bit makes the low bit of bcd_o disagree with the count parity at the next edge. A ring that skips or sticks shows up as a wrong upper BCD field within at most two counts, and the carry then lands on the wrong cycle. In a chain, a carry that is missing or doubled corrupts a higher digit on that same edge. Because of this, a comparison of every digit after every edge against an arithmetic count finds any such fault within one decade cycle of ten counts.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int unsigned RING_LEN_DEF = 5;

  function automatic int unsigned pos_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/bq_toggle.sv
module bq_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic t_o,
  output logic wrap_o
);
  logic t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    t_q <= 1'b0;
    else if (clr_i) t_q <= 1'b0;
    else if (en_i)  t_q <= ~t_q;
  end

  assign t_o    = t_q;
  assign wrap_o = en_i & t_q & ~clr_i;

  // R2
  toggle_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (t_q != $past(t_q)));
  // R3
  toggle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(t_q));
endmodule

// File: rtl/bq_ring.sv
module bq_ring #(
  parameter int unsigned RING_LEN = bq_pkg::RING_LEN_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  input  logic                clr_i,
  output logic [RING_LEN-1:0] ring_o,
  output logic                last_o
);
  localparam logic [RING_LEN-1:0] HOME = {{(RING_LEN-1){1'b0}}, 1'b1};

  logic [RING_LEN-1:0] ring_q, ring_next;
  logic                legal;

  assign legal = (ring_q != '0) && ((ring_q & (ring_q - 1'b1)) == '0);

  generate
    if (RING_LEN == 1) begin : g_single
      assign ring_next = HOME;
    end else begin : g_rot
      assign ring_next = legal ? {ring_q[RING_LEN-2:0], ring_q[RING_LEN-1]} : HOME;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ring_q <= HOME;
    else if (clr_i) ring_q <= HOME;
    else if (adv_i) ring_q <= ring_next;
  end

  assign ring_o = ring_q;
  assign last_o = ring_q[RING_LEN-1];

  // R6
  ring_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(ring_q));
  // R3
  ring_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(ring_q));
endmodule

// File: rtl/bq_encode.sv
module bq_encode #(
  parameter int unsigned RING_LEN = bq_pkg::RING_LEN_DEF,
  parameter int unsigned POS_W    = bq_pkg::pos_bits(RING_LEN),
  parameter int unsigned BCD_W    = POS_W + 1
) (
  input  logic [RING_LEN-1:0] ring_i,
  input  logic                t_i,
  output logic [BCD_W-1:0]    bcd_o
);
  logic [POS_W-1:0] pos;
  logic             legal;

  assign legal = (ring_i != '0) && ((ring_i & (ring_i - 1'b1)) == '0);

  always_comb begin
    pos = '0;
    for (int i = 0; i < RING_LEN; i++) begin
      if (ring_i[i]) pos = pos | i[POS_W-1:0];
    end
  end

  assign bcd_o = legal ? {pos, t_i} : '0;
endmodule

// File: rtl/bq_decade.sv
module bq_decade #(
  parameter int unsigned RING_LEN = bq_pkg::RING_LEN_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  output logic [3:0] bcd_o,
  output logic       carry_o
);
  localparam int unsigned POS_W = bq_pkg::pos_bits(RING_LEN);
  localparam int unsigned BCD_W = POS_W + 1;
  localparam logic [BCD_W-1:0] TOP_VAL = BCD_W'(2 * RING_LEN - 1);

  logic                t_bit, t_wrap, ring_last;
  logic [RING_LEN-1:0] ring;
  logic [BCD_W-1:0]    code;

  bq_toggle u_toggle (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i), .clr_i(clr_i),
    .t_o   (t_bit), .wrap_o(t_wrap)
  );

  bq_ring #(.RING_LEN(RING_LEN)) u_ring (
    .clk_i (clk_i), .rst_ni(rst_ni), .adv_i(t_wrap), .clr_i(clr_i),
    .ring_o(ring),  .last_o(ring_last)
  );

  bq_encode #(.RING_LEN(RING_LEN), .POS_W(POS_W), .BCD_W(BCD_W)) u_encode (
    .ring_i(ring), .t_i(t_bit), .bcd_o(code)
  );

  assign bcd_o   = 4'(code);
  assign carry_o = t_wrap & ring_last;

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (code == (($past(code) == TOP_VAL) ? '0 : $past(code) + 1'b1)));
  // R3
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(code));
  // R4
  carry_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o == (en_i && !clr_i && code == TOP_VAL));
  // R5
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (code == '0));
  // R6
  digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code <= TOP_VAL);
endmodule

// File: tb/bq_decade_bench.sv
module bq_decade_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_DIG      = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic clr = 1'b0;
  logic [3:0] bcd [N_DIG];
  logic       cy  [N_DIG];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bq_decade u_bq_decade (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr),
    .bcd_o(bcd[0]), .carry_o(cy[0])
  );

  for (genvar k = 1; k < N_DIG; k++) begin : g_chain
    bq_decade u_dig (
      .clk_i(clk), .rst_ni(rst_n), .en_i(cy[k-1]), .clr_i(clr),
      .bcd_o(bcd[k]), .carry_o(cy[k])
    );
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_chain(input longint total);
    longint v = total % 10000000;
    for (int k = 0; k < N_DIG; k++) begin
      check(k == 0 ? "R2" : "R7", int'(bcd[k]), int'(v % 10));
      v = v / 10;
    end
  endtask

  // one cycle: drive at negedge, check carry, then digits after the edge
  task automatic step(input bit e, input bit c, inout longint total);
    @(negedge clk);
    en = e; clr = c;
    #1;
    check("R4", int'(cy[0]), (e && !c && (total % 10) == 9) ? 1 : 0);
    @(posedge clk);
    #1;
    if (c) total = 0;
    else if (e) total = total + 1;
    check_chain(total);
  endtask

  initial begin
    longint total = 0;
    int     ncy;
    logic [15:0] lfsr = 16'hACE1;
    #(CLK_PERIOD*2 + 2);
    // R1 while in reset
    check("R1", int'(bcd[0]), 0);
    check("R1", int'(cy[0]), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(bcd[0]), 0);
    check("R1", int'(cy[0]), 0);

    // R3 hold without enable
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, total);
    check("R3", int'(bcd[0]), 0);

    // R6 ten counts from clear: one carry, back to 0
    step(1'b0, 1'b1, total);
    ncy = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); en = 1'b1; clr = 1'b0; #1;
      if (cy[0]) ncy++;
      check("R6", int'(bcd[0] <= 4'd9), 1);
      @(posedge clk); #1; total++;
    end
    check("R6", ncy, 1);
    check("R6", int'(bcd[0]), 0);

    // R5 clear at 9 with enable: no carry, zero next
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0, total);
    check("R5", int'(bcd[0]), 9);
    @(negedge clk); en = 1'b1; clr = 1'b1; #1;
    check("R5", int'(cy[0]), 0);
    @(posedge clk); #1; total = 0;
    check("R5", int'(bcd[0]), 0);
    check_chain(total);

    // R2/R3/R7 pseudo-random enables, rare clears
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], (lfsr[15:8] == 8'h5A), total);
    end

    // R7 long run so the upper digits move
    for (int i = 0; i < 25000; i++) step(1'b1, 1'b0, total);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule